// File: doc/BRIEF.md
# Power-up strap and test-mode controller

This block captures the board-level configuration straps of the chip while the supply power-up reset is active. It keeps the captured values until the next power-up reset. While that reset is asserted, the strap pins are released to high impedance so that their internal pull-ups can set a default level. An external pull-down resistor turns that default into a low level. The last level seen before the reset ends is the one that is kept.

From the captured straps the block derives two things. The first is the I/O location of the configuration index/data port pair. The second is the test mode. In normal operation every pin may drive. The in-circuit-test mode floats every output, including the chain output, so that a bed-of-nails tester can drive the board freely. The XOR-chain mode turns every signal pin into an input and folds those inputs through a chain of XOR gates into one dedicated output. Pins marked as supply pins in a parameter mask stay out of that chain.

Top module: `strap_testmode_ctrl`

## Requirements
- R1: While `por_n` is low, `strap_pu_en` is 1, `pin_oe` is 0 on every pin set in `STRAP_MASK` and 1 on every other pin, and `mode_ict`, `mode_xor`, `mode_rsvd` and `xor_oe` are 0.
- R2: The straps that take effect are the ones present at the last rising clock edge with `por_n` low. Any strap change after `por_n` goes high has no effect on any output until the next power-up reset.
- R3: A captured address strap of 0 gives `base_hi`=0, `index_port`=16'h002E and `data_port`=16'h002F. A captured address strap of 1 gives `base_hi`=1, `index_port`=16'h164E and `data_port`=16'h164F.
- R4: Out of reset, captured {TEST,TRIS}=2'b11 selects normal operation: `pin_oe` is all ones, `xor_oe`=0, `xor_out`=0 and all three mode flags are 0.
- R5: Out of reset, captured {TEST,TRIS}=2'b10 selects in-circuit test: `mode_ict`=1, `pin_oe` is all zeros and `xor_oe`=0.
- R6: Out of reset, captured {TEST,TRIS}=2'b01 selects XOR-chain test: `mode_xor`=1, `pin_oe` is all zeros, `xor_oe`=1, and `xor_out` equals the parity of (`pin_in` & `CHAIN_MASK`), following `pin_in` combinationally.
- R7: Pins whose `CHAIN_MASK` bit is 0 (supply pins; bits 3 and 6 by default) never change `xor_out`.
- R8: Captured {TEST,TRIS}=2'b00 (reserved) behaves as normal operation for `pin_oe`, `xor_oe` and `xor_out`, and raises `mode_rsvd`=1.
- R9: From the first rising edge with `por_n` high onward, `strap_pu_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Supply power-up reset, active low, synchronous |
| strap_addr_sel | input | 1 | Address-select strap level |
| strap_test | input | 1 | TEST strap level |
| strap_tris | input | 1 | TRIS strap level |
| pin_in | input | NPINS | Input levels of the pads |
| pin_oe | output | NPINS | Per-pad output-enable permission (1 = may drive) |
| strap_pu_en | output | 1 | Strap pull-up enable during power-up reset |
| base_hi | output | 1 | Captured address select |
| index_port | output | 16 | I/O address of the index register |
| data_port | output | 16 | I/O address of the data register |
| mode_ict | output | 1 | In-circuit-test mode active |
| mode_xor | output | 1 | XOR-chain mode active |
| mode_rsvd | output | 1 | Reserved strap code was captured |
| xor_out | output | 1 | XOR chain result |
| xor_oe | output | 1 | Output enable of the chain output |

## Verification
The bench powers the block up once with each of the eight strap combinations. Before each release it checks the reset-time pin state. Right after each release it scrambles the straps. A sampler that kept tracking its inputs would then report the inverse mode or base address.

In XOR-chain mode every one of the 256 pin patterns is applied, and `xor_out` is compared against the computed masked parity. A chain that included a supply pin, or that dropped a signal pin, shows up as a parity mismatch. Separate checks flip only the excluded pins.

The reserved code is checked for a missing flag, and for wrongly entering a floating or chain mode, either of which would leave the board undriven.

// File: rtl/strap_pkg.sv
// Shared types and constants for the strap/test-mode controller.
// Assumes: two-bit test code is {TEST,TRIS}, a strap level of 1 means no pull-down.
package strap_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL = 2'd0,
        TM_ICT    = 2'd1,
        TM_XOR    = 2'd2,
        TM_RSVD   = 2'd3
    } tmode_e;

    localparam logic [15:0] PORT_LOW_BASE  = 16'h002E;
    localparam logic [15:0] PORT_HIGH_BASE = 16'h164E;

    // Maps the captured {TEST,TRIS} pair onto an operating mode.
    function automatic tmode_e decode_mode(input logic test_lvl, input logic tris_lvl);
        unique case ({test_lvl, tris_lvl})
            2'b11:   decode_mode = TM_NORMAL;
            2'b10:   decode_mode = TM_ICT;
            2'b01:   decode_mode = TM_XOR;
            default: decode_mode = TM_RSVD;
        endcase
    endfunction

endpackage

// File: rtl/strap_sampler.sv
// Captures the strap levels on every clock edge while the power-up reset is
// low and freezes them once it rises; also tracks the reset phase.
// Assumes: por_n is synchronous to clk and is the only reset of this register.
module strap_sampler #(
    parameter int NSTRAPS = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [NSTRAPS-1:0] strap_in,
    output logic [NSTRAPS-1:0] strap_q,
    output logic               in_por
);

    // Track straps during power-up reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            strap_q <= strap_in;
            in_por  <= 1'b1;
        end else begin
            in_por  <= 1'b0;
        end
    end

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        !in_por |=> $stable(strap_q));

    // R9
    por_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        in_por |=> !in_por);

endmodule

// File: rtl/mode_decode.sv
// Turns the captured straps into port addresses, mode flags and per-pin
// output-enable permissions.
// Assumes: strap pins are listed in STRAP_MASK and float while in_por is high.
module mode_decode
    import strap_pkg::*;
#(
    parameter int               NPINS      = 8,
    parameter logic [NPINS-1:0] STRAP_MASK = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             in_por,
    input  logic             sel_addr,
    input  logic             sel_test,
    input  logic             sel_tris,
    output logic [NPINS-1:0] pin_oe,
    output logic             pu_en,
    output logic             base_hi,
    output logic [15:0]      index_port,
    output logic [15:0]      data_port,
    output logic             mode_ict,
    output logic             mode_xor,
    output logic             mode_rsvd,
    output logic             xor_en
);

    localparam logic [NPINS-1:0] ALL_ON = '1;

    tmode_e mode;

    // Mode selection, suppressed while the power-up reset is running.
    always_comb begin
        mode      = decode_mode(sel_test, sel_tris);
        mode_ict  = !in_por && (mode == TM_ICT);
        mode_xor  = !in_por && (mode == TM_XOR);
        mode_rsvd = !in_por && (mode == TM_RSVD);
        xor_en    = mode_xor;
        pu_en     = in_por;
    end

    // Pin drive permissions: strap pins float in reset, all float in test modes.
    always_comb begin
        if (in_por)
            pin_oe = ~STRAP_MASK;
        else if (mode_ict || mode_xor)
            pin_oe = '0;
        else
            pin_oe = ALL_ON;
    end

    // Configuration port pair location from the address strap.
    always_comb begin
        base_hi    = sel_addr;
        index_port = sel_addr ? PORT_HIGH_BASE : PORT_LOW_BASE;
        data_port  = index_port + 16'd1;
    end

    // R5
    ict_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        mode_ict |-> (pin_oe == '0) && !xor_en);

    // R8
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({mode_ict, mode_xor, mode_rsvd}));

endmodule

// File: rtl/xor_chain.sv
// Folds the masked pad inputs through a ripple of XOR gates into one bit.
// Assumes: CHAIN_MASK bits that are 0 mark supply pads kept out of the chain.
module xor_chain #(
    parameter int               NPINS      = 8,
    parameter logic [NPINS-1:0] CHAIN_MASK = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [NPINS-1:0] pins,
    input  logic             en,
    output logic             chain_out
);

    logic [NPINS:0] link;

    assign link[0] = 1'b0;

    // One XOR stage per pad position, in pad index order.
    for (genvar i = 0; i < NPINS; i++) begin : g_stage
        assign link[i+1] = link[i] ^ (pins[i] & CHAIN_MASK[i]);
    end

    // Chain result reaches the pad only in chain mode.
    always_comb begin
        chain_out = en & link[NPINS];
    end

    // R6
    chain_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        !en |-> !chain_out);

endmodule

// File: rtl/strap_testmode_ctrl.sv
// Power-up strap capture and test-mode control for the pad ring.
// Assumes: por_n is the supply power-up reset only; later resets never
// reach this block, so captured straps survive them.
module strap_testmode_ctrl #(
    parameter int               NPINS      = 8,
    parameter logic [NPINS-1:0] CHAIN_MASK = 8'b1011_0111,
    parameter logic [NPINS-1:0] STRAP_MASK = 8'b1000_0011
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             strap_addr_sel,
    input  logic             strap_test,
    input  logic             strap_tris,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_oe,
    output logic             strap_pu_en,
    output logic             base_hi,
    output logic [15:0]      index_port,
    output logic [15:0]      data_port,
    output logic             mode_ict,
    output logic             mode_xor,
    output logic             mode_rsvd,
    output logic             xor_out,
    output logic             xor_oe
);

    localparam int NSTRAPS = 3;

    logic [NSTRAPS-1:0] strap_q;
    logic               in_por;
    logic               xor_en;

    strap_sampler #(.NSTRAPS(NSTRAPS)) u_sample (
        .clk      (clk),
        .por_n    (por_n),
        .strap_in ({strap_addr_sel, strap_test, strap_tris}),
        .strap_q  (strap_q),
        .in_por   (in_por)
    );

    mode_decode #(.NPINS(NPINS), .STRAP_MASK(STRAP_MASK)) u_decode (
        .clk        (clk),
        .por_n      (por_n),
        .in_por     (in_por),
        .sel_addr   (strap_q[2]),
        .sel_test   (strap_q[1]),
        .sel_tris   (strap_q[0]),
        .pin_oe     (pin_oe),
        .pu_en      (strap_pu_en),
        .base_hi    (base_hi),
        .index_port (index_port),
        .data_port  (data_port),
        .mode_ict   (mode_ict),
        .mode_xor   (mode_xor),
        .mode_rsvd  (mode_rsvd),
        .xor_en     (xor_en)
    );

    xor_chain #(.NPINS(NPINS), .CHAIN_MASK(CHAIN_MASK)) u_chain (
        .clk       (clk),
        .por_n     (por_n),
        .pins      (pin_in),
        .en        (xor_en),
        .chain_out (xor_out)
    );

    assign xor_oe = xor_en;

    // R6
    xor_drive_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        xor_oe |-> (pin_oe == '0));

    // R1
    por_pullup_chk: assert property (@(posedge clk) disable iff (!por_n)
        strap_pu_en |-> !xor_oe && !mode_ict && !mode_rsvd);

endmodule

// File: tb/sim_strap_testmode_ctrl.sv
module sim_strap_testmode_ctrl;

    localparam int         NPINS = 8;
    localparam logic [7:0] CMASK = 8'b1011_0111;
    localparam logic [7:0] SMASK = 8'b1000_0011;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             s_addr = 1'b1, s_test = 1'b1, s_tris = 1'b1;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_oe;
    logic             strap_pu_en, base_hi, mode_ict, mode_xor, mode_rsvd, xor_out, xor_oe;
    logic [15:0]      index_port, data_port;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    strap_testmode_ctrl #(.NPINS(NPINS), .CHAIN_MASK(CMASK), .STRAP_MASK(SMASK)) u0 (
        .clk(clk), .por_n(por_n), .strap_addr_sel(s_addr), .strap_test(s_test),
        .strap_tris(s_tris), .pin_in(pin_in), .pin_oe(pin_oe), .strap_pu_en(strap_pu_en),
        .base_hi(base_hi), .index_port(index_port), .data_port(data_port),
        .mode_ict(mode_ict), .mode_xor(mode_xor), .mode_rsvd(mode_rsvd),
        .xor_out(xor_out), .xor_oe(xor_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Power up with the given straps, checking the reset-time pad state.
    task automatic power_up(input logic a, input logic t, input logic r);
        @(negedge clk);
        por_n = 1'b0; s_addr = a; s_test = t; s_tris = r;
        repeat (3) @(negedge clk);
        check("R1 pullup", {31'd0, strap_pu_en}, 32'd1);
        check("R1 pin_oe", {24'd0, pin_oe}, {24'd0, ~SMASK});
        check("R1 flags", {28'd0, mode_ict, mode_xor, mode_rsvd, xor_oe}, 32'd0);
        por_n = 1'b1;
        s_addr = ~a; s_test = ~t; s_tris = ~r;   // R2: late strap changes
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int code = 0; code < 8; code++) begin
            logic a, t, r;
            logic is_ict, is_xor, is_rsvd;
            a = code[2]; t = code[1]; r = code[0];
            is_ict  = ({t, r} == 2'b10);
            is_xor  = ({t, r} == 2'b01);
            is_rsvd = ({t, r} == 2'b00);
            power_up(a, t, r);

            // R9
            check("R9 pullup off", {31'd0, strap_pu_en}, 32'd0);
            // R3
            check("R3 base_hi", {31'd0, base_hi}, {31'd0, a});
            check("R3 index", {16'd0, index_port}, a ? 32'h164E : 32'h002E);
            check("R3 data", {16'd0, data_port}, a ? 32'h164F : 32'h002F);
            // R4 R5 R6 R8 mode flags
            check("R5 mode_ict", {31'd0, mode_ict}, {31'd0, is_ict});
            check("R6 mode_xor", {31'd0, mode_xor}, {31'd0, is_xor});
            check("R8 mode_rsvd", {31'd0, mode_rsvd}, {31'd0, is_rsvd});
            check("R4 pin_oe", {24'd0, pin_oe}, (is_ict || is_xor) ? 32'd0 : 32'hFF);
            check("R6 xor_oe", {31'd0, xor_oe}, {31'd0, is_xor});

            // Exhaustive pad sweep; chain output is combinational.
            for (int p = 0; p < 256; p++) begin
                logic [7:0] pv;
                pv = p[7:0];
                @(negedge clk);
                pin_in = pv;
                #1;
                check(is_xor ? "R6 parity" : "R4 xor idle", {31'd0, xor_out},
                      {31'd0, is_xor & (^(pv & CMASK))});
            end

            // R7: flipping only supply pads leaves the chain unchanged.
            if (is_xor) begin
                logic ref_bit;
                @(negedge clk); pin_in = 8'h25; #1; ref_bit = xor_out;
                @(negedge clk); pin_in = 8'h25 ^ ~CMASK; #1;
                check("R7 excluded pins", {31'd0, xor_out}, {31'd0, ref_bit});
                check("R7 parity value", {31'd0, ref_bit}, {31'd0, ^(8'h25 & CMASK)});
            end

            // R2: after many cycles with scrambled straps, state is unchanged.
            repeat (5) @(negedge clk);
            check("R2 hold base", {16'd0, index_port}, a ? 32'h164E : 32'h002E);
            check("R2 hold mode", {29'd0, mode_ict, mode_xor, mode_rsvd},
                  {29'd0, is_ict, is_xor, is_rsvd});
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule